// File: doc/BRIEF.md
# Pulse Width Capture with Overrun Lockout

This block times an external digital signal with a free-running counter. After the start bit is set and one of three capture modes is selected, it measures either the width of a high pulse (rising edge to the next falling edge), the period (rising edge to the next rising edge), or both in turn. When a measurement ends, the count is placed in a result register and a full flag is raised. While that flag stays up, later results are thrown away so that an unread value is never overwritten. The one exception is the combined mode: there, the high-pulse result is always written and only the period result obeys the lockout.

The external signal passes through a two-flop synchronizer and an edge detector before it reaches a four-state controller. The controller has the states ST_IDLE, ST_ARMED, ST_MEAS_HIGH and ST_MEAS_CYC, and it tells a shared counter when to clear and when to count. A counter wrap while measuring raises a sticky overflow flag, and software clears that flag by writing a zero to it. A cascade input doubles the counter and result width. In cascade mode the result is read through two halves, and only the read strobe of the upper half releases the lockout.

The controller transitions are:
- T_ARM: ST_IDLE to ST_ARMED, when the start bit is set and a capture mode is selected.
- T_ABORT: any state to ST_IDLE, when the start bit is cleared or a non-capture mode is selected.
- T_BEGIN_HIGH: ST_ARMED to ST_MEAS_HIGH, on a rise in high-pulse or combined mode.
- T_BEGIN_CYC: ST_ARMED to ST_MEAS_CYC, on a rise in period mode.
- T_HIGH_DONE: ST_MEAS_HIGH to ST_ARMED, on a fall in high-pulse mode. The result is stored and the counter cleared.
- T_HIGH_TO_CYC: ST_MEAS_HIGH to ST_MEAS_CYC, on a fall in combined mode. The result is stored with the lockout bypassed, and the counter keeps running.
- T_CYC_DONE: ST_MEAS_CYC back to itself, on a rise in period mode. The result is stored and the counter cleared.
- T_CYC_TO_HIGH: ST_MEAS_CYC to ST_MEAS_HIGH, on a rise in combined mode. The result is stored and the counter cleared.

Top module: `pwcap_top`

## Requirements
- R1: In high-pulse mode (mode code 4'b1000), the block stores D when a rising edge of sig_i is followed D clocks later by a falling edge, and it sets full_o at the same edge.
- R2: A pulse on rd_lo_i clears the full flag when cascade_i is 0, and a pulse on rd_hi_i clears it when cascade_i is 1. If a store happens in the same cycle as the read, the flag is set.
- R3: While the full flag is 1, the result register keeps its value, and any result that completes is discarded. Combined mode is the exception described in R5.
- R4: In period mode (mode code 4'b1010), the stored value is the number of clocks between two consecutive rising edges of sig_i.
- R5: In combined mode (mode code 4'b1001), the high-pulse result is stored even when the full flag is 1. The period result (rise to rise, counted through the high pulse) is stored only when the flag is 0.
- R6: For any mode code other than 4'b1000, 4'b1010 and 4'b1001, full_o reads 0, and the flag value is retained for when a capture mode returns. Bit 1 of a flag write never changes the flag.
- R7: If the counter wraps while measuring, ovf_o is set. A flag write with bit 0 = 0 clears ovf_o, and a flag write with bit 0 = 1 leaves it unchanged.
- R8: When cascade_i is 1, the counter and the result are 2*HALF_W bits wide, and data_hi_o holds the upper half. A pulse on rd_lo_i then leaves the full flag set.
- R9: After reset, data_lo_o, data_hi_o, full_o and ovf_o are all 0.
- R10: A result appears on the third rising clock edge after the sig_i change that ends the measurement.
- R11: While start_i is 0, no result is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 4 | Capture mode code |
| start_i | input | 1 | Run enable |
| cascade_i | input | 1 | Selects the double-width counter and result |
| sig_i | input | 1 | Asynchronous signal to be measured |
| rd_lo_i | input | 1 | Read strobe for the lower result half |
| rd_hi_i | input | 1 | Read strobe for the upper result half |
| flg_wr_i | input | 1 | Flag write strobe |
| flg_wdata_i | input | 2 | Flag write data: bit 1 is the full flag (ignored), bit 0 is the overflow flag |
| data_lo_o | output | HALF_W | Lower half of the result |
| data_hi_o | output | HALF_W | Upper half of the result |
| full_o | output | 1 | Result-full flag |
| ovf_o | output | 1 | Overflow flag |

## Verification
A result and its full flag are due on the third rising edge after the sig_i change that ends the measurement. One directed check samples at the falling edge just before that rising edge and at the falling edge just after it, to confirm the exact cycle. A read strobe or flag write takes effect at the next rising edge. The bench drives every input on falling edges and samples outputs on falling edges. Before it checks a measured result, it leaves at least six idle cycles after the last change of sig_i.

// File: rtl/pwcap_pkg.sv
package pwcap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_MEAS_HIGH,
        ST_MEAS_CYC
    } pwc_state_e;

    localparam logic [3:0] MODE_HIGH = 4'b1000;
    localparam logic [3:0] MODE_CYC  = 4'b1010;
    localparam logic [3:0] MODE_COMB = 4'b1001;

    function automatic logic is_capture(input logic [3:0] m);
        return (m == MODE_HIGH) || (m == MODE_CYC) || (m == MODE_COMB);
    endfunction

endpackage

// File: rtl/pwcap_sync.sv
module pwcap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o,
    output logic fall_o
);
    // pipe[STAGES-1] is the synchronized level; pipe[STAGES] is its previous value
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[STAGES-1:0], sig_i};
        end
    end

    assign rise_o =  pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall_o = ~pipe_q[STAGES-1] &  pipe_q[STAGES];
endmodule

// File: rtl/pwcap_fsm.sv
module pwcap_fsm
    import pwcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [3:0] mode_i,
    input  logic       rise_i,
    input  logic       fall_i,
    output logic       cnt_clr_o,
    output logic       cnt_run_o,
    output logic       store_o,
    output logic       store_force_o
);
    pwc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d       = state_q;
        cnt_clr_o     = 1'b0;
        cnt_run_o     = 1'b0;
        store_o       = 1'b0;
        store_force_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_clr_o = 1'b1;
                if (run_i) begin
                    state_d = ST_ARMED;                       // T_ARM
                end
            end
            ST_ARMED: begin
                cnt_clr_o = 1'b1;
                if (!run_i) begin
                    state_d = ST_IDLE;                        // T_ABORT
                end else if (rise_i) begin
                    state_d = (mode_i == MODE_CYC) ? ST_MEAS_CYC   // T_BEGIN_CYC
                                                   : ST_MEAS_HIGH; // T_BEGIN_HIGH
                end
            end
            ST_MEAS_HIGH: begin
                if (!run_i) begin
                    cnt_clr_o = 1'b1;
                    state_d   = ST_IDLE;                      // T_ABORT
                end else begin
                    cnt_run_o = 1'b1;
                    if (fall_i) begin
                        store_o = 1'b1;
                        if (mode_i == MODE_COMB) begin
                            store_force_o = 1'b1;
                            state_d       = ST_MEAS_CYC;      // T_HIGH_TO_CYC
                        end else begin
                            cnt_clr_o = 1'b1;
                            state_d   = ST_ARMED;             // T_HIGH_DONE
                        end
                    end
                end
            end
            ST_MEAS_CYC: begin
                if (!run_i) begin
                    cnt_clr_o = 1'b1;
                    state_d   = ST_IDLE;                      // T_ABORT
                end else begin
                    cnt_run_o = 1'b1;
                    if (rise_i) begin
                        store_o   = 1'b1;
                        cnt_clr_o = 1'b1;
                        state_d   = (mode_i == MODE_COMB) ? ST_MEAS_HIGH  // T_CYC_TO_HIGH
                                                          : ST_MEAS_CYC;  // T_CYC_DONE
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/pwcap_cnt.sv
module pwcap_cnt #(
    parameter int HALF_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wide_i,
    input  logic                clr_i,
    input  logic                run_i,
    output logic [2*HALF_W-1:0] cap_val_o,
    output logic                ovf_evt_o
);
    localparam int CW = 2 * HALF_W;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] mask;
    logic [CW-1:0] inc;

    assign mask      = wide_i ? {CW{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    assign inc       = (cnt_q + 1'b1) & mask;
    assign cap_val_o = inc;
    assign ovf_evt_o = run_i && (cnt_q == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= inc;
        end
    end
endmodule

// File: rtl/pwcap_result.sv
module pwcap_result #(
    parameter int HALF_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                store_i,
    input  logic                force_i,
    input  logic [2*HALF_W-1:0] cap_val_i,
    input  logic                wide_i,
    input  logic                rd_lo_i,
    input  logic                rd_hi_i,
    input  logic                ovf_evt_i,
    input  logic                flg_wr_i,
    input  logic [1:0]          flg_wdata_i,
    output logic [2*HALF_W-1:0] data_o,
    output logic                full_o,
    output logic                ovf_o
);
    logic accept;
    logic rd_hit;
    logic unused_full_wr;

    // bit 1 of a flag write targets the full flag, which software cannot change
    assign unused_full_wr = flg_wdata_i[1];

    assign accept = store_i && (!full_o || force_i);
    assign rd_hit = wide_i ? rd_hi_i : rd_lo_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o <= '0;
            full_o <= 1'b0;
            ovf_o  <= 1'b0;
        end else begin
            if (accept) begin
                data_o <= cap_val_i;
            end
            if (accept) begin
                full_o <= 1'b1;
            end else if (rd_hit) begin
                full_o <= 1'b0;
            end
            if (ovf_evt_i) begin
                ovf_o <= 1'b1;
            end else if (flg_wr_i && !flg_wdata_i[0]) begin
                ovf_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pwcap_top.sv
module pwcap_top
    import pwcap_pkg::*;
#(
    parameter int HALF_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        mode_i,
    input  logic              start_i,
    input  logic              cascade_i,
    input  logic              sig_i,
    input  logic              rd_lo_i,
    input  logic              rd_hi_i,
    input  logic              flg_wr_i,
    input  logic [1:0]        flg_wdata_i,
    output logic [HALF_W-1:0] data_lo_o,
    output logic [HALF_W-1:0] data_hi_o,
    output logic              full_o,
    output logic              ovf_o
);
    localparam int CW = 2 * HALF_W;

    logic          cap_mode;
    logic          run;
    logic          rise, fall;
    logic          cnt_clr, cnt_run, store, store_force;
    logic [CW-1:0] cap_val;
    logic          ovf_evt;
    logic [CW-1:0] data;
    logic          full_q;

    assign cap_mode = is_capture(mode_i);
    assign run      = start_i && cap_mode;

    pwcap_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (sig_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    pwcap_fsm i_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_i         (run),
        .mode_i        (mode_i),
        .rise_i        (rise),
        .fall_i        (fall),
        .cnt_clr_o     (cnt_clr),
        .cnt_run_o     (cnt_run),
        .store_o       (store),
        .store_force_o (store_force)
    );

    pwcap_cnt #(.HALF_W(HALF_W)) i_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide_i    (cascade_i),
        .clr_i     (cnt_clr),
        .run_i     (cnt_run),
        .cap_val_o (cap_val),
        .ovf_evt_o (ovf_evt)
    );

    pwcap_result #(.HALF_W(HALF_W)) i_result (
        .clk         (clk),
        .rst_n       (rst_n),
        .store_i     (store),
        .force_i     (store_force),
        .cap_val_i   (cap_val),
        .wide_i      (cascade_i),
        .rd_lo_i     (rd_lo_i),
        .rd_hi_i     (rd_hi_i),
        .ovf_evt_i   (ovf_evt),
        .flg_wr_i    (flg_wr_i),
        .flg_wdata_i (flg_wdata_i),
        .data_o      (data),
        .full_o      (full_q),
        .ovf_o       (ovf_o)
    );

    assign data_lo_o = data[HALF_W-1:0];
    assign data_hi_o = data[CW-1:HALF_W];
    assign full_o    = full_q && cap_mode;
endmodule

// File: rtl/pwcap_chk.sv
module pwcap_chk
    import pwcap_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        mode_i,
    input logic              cascade_i,
    input logic              rd_lo_i,
    input logic              rd_hi_i,
    input logic              flg_wr_i,
    input logic [1:0]        flg_wdata_i,
    input logic [HALF_W-1:0] data_lo_o,
    input logic [HALF_W-1:0] data_hi_o,
    input logic              full_o,
    input logic              ovf_o
);
    AST_STORE_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable({data_hi_o, data_lo_o}) && is_capture(mode_i)) |-> full_o);  // R1

    AST_FULL_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full_o) |-> ($past(rd_lo_i) || $past(rd_hi_i) || !is_capture(mode_i)));  // R2

    AST_LOCKED_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && mode_i != MODE_COMB) |=> $stable({data_hi_o, data_lo_o}));  // R3

    AST_OVF_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_wr_i && flg_wdata_i[0] && ovf_o) |=> ovf_o);  // R7

    AST_OVF_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_o) |-> $past(flg_wr_i && !flg_wdata_i[0]));  // R7

    AST_WIDE_LOW_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade_i && rd_lo_i && !rd_hi_i && full_o) |=> (full_o || !is_capture(mode_i)));  // R8
endmodule

bind pwcap_top pwcap_chk #(.HALF_W(HALF_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .cascade_i   (cascade_i),
    .rd_lo_i     (rd_lo_i),
    .rd_hi_i     (rd_hi_i),
    .flg_wr_i    (flg_wr_i),
    .flg_wdata_i (flg_wdata_i),
    .data_lo_o   (data_lo_o),
    .data_hi_o   (data_hi_o),
    .full_o      (full_o),
    .ovf_o       (ovf_o)
);

// File: tb/test_pwcap_top.sv
module test_pwcap_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_W     = 8;

    typedef struct packed {
        logic [3:0] mode;
        logic [7:0] hi;
        logic [7:0] lo;
        logic [7:0] exp;
    } vec_t;

    // Pattern per row: a high pulse of .hi clocks, .lo clocks low, then a 2-clock high pulse
    localparam vec_t VECS [6] = '{
        '{4'b1000, 8'd5,  8'd7, 8'd5 },   // R1 R3: second pulse dropped
        '{4'b1000, 8'd20, 8'd3, 8'd20},   // R1 R3
        '{4'b1010, 8'd5,  8'd7, 8'd12},   // R4
        '{4'b1010, 8'd1,  8'd1, 8'd2 },   // R4 shortest period
        '{4'b1001, 8'd6,  8'd9, 8'd2 },   // R5: cycle dropped, second high forced in
        '{4'b1001, 8'd3,  8'd4, 8'd2 }    // R5
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [3:0]        mode_i = 4'b0000;
    logic              start_i = 1'b0;
    logic              cascade_i = 1'b0;
    logic              sig_i = 1'b0;
    logic              rd_lo_i = 1'b0;
    logic              rd_hi_i = 1'b0;
    logic              flg_wr_i = 1'b0;
    logic [1:0]        flg_wdata_i = 2'b00;
    logic [HALF_W-1:0] data_lo_o;
    logic [HALF_W-1:0] data_hi_o;
    logic              full_o;
    logic              ovf_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwcap_top #(.HALF_W(HALF_W)) i_pwcap_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .start_i     (start_i),
        .cascade_i   (cascade_i),
        .sig_i       (sig_i),
        .rd_lo_i     (rd_lo_i),
        .rd_hi_i     (rd_hi_i),
        .flg_wr_i    (flg_wr_i),
        .flg_wdata_i (flg_wdata_i),
        .data_lo_o   (data_lo_o),
        .data_hi_o   (data_hi_o),
        .full_o      (full_o),
        .ovf_o       (ovf_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic read_lo();
        rd_lo_i = 1'b1; tick(1); rd_lo_i = 1'b0;
    endtask

    task automatic read_hi();
        rd_hi_i = 1'b1; tick(1); rd_hi_i = 1'b0;
    endtask

    task automatic flag_write(input logic [1:0] v);
        flg_wr_i = 1'b1; flg_wdata_i = v; tick(1); flg_wr_i = 1'b0; flg_wdata_i = 2'b00;
    endtask

    task automatic pattern(input int hi, input int lo);
        sig_i = 1'b0; tick(4);
        sig_i = 1'b1; tick(hi);
        sig_i = 1'b0; tick(lo);
        sig_i = 1'b1; tick(2);
        sig_i = 1'b0; tick(6);
    endtask

    task automatic prepare(input logic [3:0] m, input logic wide);
        start_i = 1'b0; mode_i = m; cascade_i = wide; tick(2);
        if (wide) read_hi(); else read_lo();
        start_i = 1'b1; tick(2);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R9 data_lo", int'(data_lo_o), 0);
        check("R9 data_hi", int'(data_hi_o), 0);
        check("R9 full", int'(full_o), 0);
        check("R9 ovf", int'(ovf_o), 0);

        // R11: stopped block stores nothing
        mode_i = 4'b1000; start_i = 1'b0;
        pattern(5, 7);
        check("R11 full", int'(full_o), 0);
        check("R11 data", int'(data_lo_o), 0);

        // Vector table
        for (int i = 0; i < 6; i++) begin
            prepare(VECS[i].mode, 1'b0);
            pattern(int'(VECS[i].hi), int'(VECS[i].lo));
            check("R1/R3/R4/R5 table data", int'(data_lo_o), int'(VECS[i].exp));
            check("R1 table full", int'(full_o), 1);
        end

        // R10: exact cycle of the result
        prepare(4'b1000, 1'b0);
        sig_i = 1'b0; tick(4);
        sig_i = 1'b1; tick(4);
        sig_i = 1'b0; tick(2);
        check("R10 full before third edge", int'(full_o), 0);
        tick(1);
        check("R10 full at third edge", int'(full_o), 1);
        check("R10 data", int'(data_lo_o), 4);

        // R2: read clears; R6: flag write bit1 ignored, mode gating
        read_lo();
        check("R2 full after read", int'(full_o), 0);
        pattern(9, 5);
        check("R2 new result after read", int'(data_lo_o), 9);
        flag_write(2'b00);
        check("R6 full write ignored", int'(full_o), 1);
        mode_i = 4'b0000; tick(1);
        check("R6 full reads 0 in other mode", int'(full_o), 0);
        mode_i = 4'b1000; tick(1);
        check("R6 flag retained", int'(full_o), 1);

        // R7: overflow
        prepare(4'b1000, 1'b0);
        sig_i = 1'b0; tick(4);
        sig_i = 1'b1; tick(260);
        sig_i = 1'b0; tick(6);
        check("R7 ovf set", int'(ovf_o), 1);
        check("R7 wrapped data", int'(data_lo_o), 4);
        flag_write(2'b01);
        check("R7 write 1 keeps", int'(ovf_o), 1);
        flag_write(2'b00);
        check("R7 write 0 clears", int'(ovf_o), 0);

        // R8: cascade
        prepare(4'b1000, 1'b1);
        sig_i = 1'b0; tick(4);
        sig_i = 1'b1; tick(300);
        sig_i = 1'b0; tick(6);
        check("R8 data_hi", int'(data_hi_o), 1);
        check("R8 data_lo", int'(data_lo_o), 44);
        check("R8 no ovf", int'(ovf_o), 0);
        check("R8 full", int'(full_o), 1);
        read_lo();
        check("R8 low read keeps full", int'(full_o), 1);
        read_hi();
        check("R2 high read clears in cascade", int'(full_o), 0);

        // R5: combined mode period stored once flag was read
        prepare(4'b1001, 1'b0);
        sig_i = 1'b0; tick(4);
        sig_i = 1'b1; tick(6);
        sig_i = 1'b0; tick(5);
        check("R5 high stored", int'(data_lo_o), 6);
        read_lo();
        tick(4);
        sig_i = 1'b1; tick(6);
        check("R5 period stored", int'(data_lo_o), 16);
        check("R5 period full", int'(full_o), 1);
        start_i = 1'b0; sig_i = 1'b0; tick(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule